// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block owns start-up and periodic refresh for an asynchronous DRAM driven from a synchronous controller. After reset it waits out a power-up pause measured in clock cycles. It then issues a fixed number of wake-up cycles, all of them CAS-before-RAS refreshes, and raises `init_done` once they are finished. From then on an interval timer adds one refresh credit per row slot, so that every row is covered within the refresh period. A credit makes the block raise `req`. Once `grant` is seen, the block takes the strobes and runs CAS-before-RAS refresh cycles. No row address is driven, because the device keeps its own row counter.

If credits pile up while the grant is withheld, a saturating counter holds up to `BURST_MAX` of them. When the grant arrives they are issued back to back. Between pulses of such a chain, only RAS toggles and CAS stays low. Every delay is a nanosecond parameter turned into clock cycles by ceiling division by `CLK_NS`. The RAS-low time is the larger of the minimum pulse and the CAS hold time.

The state machine has these states:
- PAUSE: power-up wait.
- IDLE: no credits.
- REQ: requesting, waiting for grant.
- CASDN: CAS low, RAS high, for the set-up time.
- RASLO: RAS low.
- PRECH: RAS precharge, with CAS kept low when the chain continues.

It has these transitions:
- PAUSE→IDLE: the pause ends and the wake-up credits are loaded.
- IDLE→REQ: a credit is pending.
- REQ→CASDN: grant is seen.
- CASDN→RASLO: set-up time done. This consumes one credit.
- RASLO→PRECH: pulse done.
- PRECH→RASLO: chain continues. This consumes a credit.
- PRECH→IDLE: chain ends. If no credit remains, this sets `init_done`.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset until PAUSE_CYC = ceil(200000 ns / CLK_NS) cycles after reset release (25000 at 8 ns), `req`, `busy` and `init_done` are 0 and all strobes are high. The first `req` comes one to two cycles after the pause ends.
- R2: After the pause, exactly INIT_CYCLES (8) refresh pulses on `ras_n` happen before `init_done` rises. Once `init_done` is set, it stays set until reset.
- R3: Every falling edge of `ras_n` is preceded by at least CSR_CYC = ceil(5 ns / CLK_NS) cycles with both CAS strobes low.
- R4: While `ras_n` is low, both `cas_lo_n` and `cas_hi_n` are low. This gives a CAS hold of at least ceil(10 ns / CLK_NS) cycles after RAS falls.
- R5: Each RAS-low pulse lasts exactly max(ceil(80 ns/CLK_NS), ceil(10 ns/CLK_NS)) cycles (10 at 8 ns). Between pulses, RAS is high for at least ceil(60 ns/CLK_NS) cycles (8).
- R6: `we_n` and `oe_n` are high at all times.
- R7: Outside a granted sequence (`busy` = 0), all strobes are high. While `grant` is withheld, `req` stays high and no strobe moves.
- R8: After `init_done`, one credit is added every INTERVAL_CYC = floor(floor(period_ns / ROWS) / CLK_NS) cycles. The period is 32 ms for ROWS = 4096 and 8 ms for ROWS = 1024, which gives 976 cycles in both cases at 8 ns. With `grant` held high, successive RAS falls are exactly INTERVAL_CYC apart.
- R9: Credits gathered while `grant` is low saturate at BURST_MAX (4). On grant they are all issued as one chain. CAS stays low through the whole chain and rises only once, at its end.
- R10: `busy` is 1 whenever RAS or CAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Bus granted to the sequencer |
| req | output | 1 | Bus wanted for refresh |
| busy | output | 1 | Strobes currently driven by the sequencer |
| init_done | output | 1 | Power-up pause and wake-up cycles complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The sequencer is driven with four grant patterns.

- Grant held high from reset exercises the pause length and the eight chained wake-up pulses.
- Grant held high after start-up shows the exact spacing of periodic refreshes, which separates a wrong interval from a wrong chain.
- Grant withheld for three and a half intervals shows that credits are kept and then replayed as one chain with a single CAS rise.
- Grant withheld for seven and a half intervals shows the saturation at four rather than a count of seven.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_REQ,
        ST_CASDN,
        ST_RASLO,
        ST_PRECH
    } ref_state_e;

    // ceiling conversion of a nanosecond delay into clock cycles
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // whole refresh period in ns for the selected row count
    function automatic int period_ns(input int rows);
        return (rows == 1024) ? 8_000_000 : 32_000_000;
    endfunction

endpackage

// File: rtl/dram_ref_tick.sv
module dram_ref_tick #(
    parameter int INTERVAL_CYC = 976
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL_CYC + 1);

    logic [TW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == TW'(INTERVAL_CYC - 1));
    assign tick   = en && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dram_ref_credit.sv
module dram_ref_credit #(
    parameter int INIT_CYCLES = 8,
    parameter int BURST_MAX   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_init,
    input  logic add,
    input  logic take,
    output logic pend_nz
);
    import dram_ref_pkg::*;

    localparam int MAXV = max_of(INIT_CYCLES, BURST_MAX);
    localparam int CW   = $clog2(MAXV + 1);

    logic [CW-1:0] cnt_q;
    logic          add_ok;

    // a new credit is dropped only when the store is full and none leaves
    assign add_ok  = add && ((cnt_q < CW'(BURST_MAX)) || take);
    assign pend_nz = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_init) begin
            cnt_q <= CW'(INIT_CYCLES);
        end else begin
            cnt_q <= cnt_q + CW'(add_ok) - CW'(take);
        end
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int CLK_NS      = 8,
    parameter int ROWS        = 4096,
    parameter int PAUSE_NS    = 200_000,
    parameter int INIT_CYCLES = 8,
    parameter int BURST_MAX   = 4,
    parameter int CSR_NS      = 5,
    parameter int CHR_NS      = 10,
    parameter int RAS_NS      = 80,
    parameter int RP_NS       = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic req,
    output logic busy,
    output logic init_done,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic we_n,
    output logic oe_n
);
    import dram_ref_pkg::*;

    localparam int PAUSE_CYC    = ns_to_cyc(PAUSE_NS, CLK_NS);
    localparam int CSR_CYC      = max_of(ns_to_cyc(CSR_NS, CLK_NS), 1);
    localparam int RAS_CYC      = max_of(ns_to_cyc(RAS_NS, CLK_NS), ns_to_cyc(CHR_NS, CLK_NS));
    localparam int RP_CYC       = max_of(ns_to_cyc(RP_NS, CLK_NS), CSR_CYC);
    localparam int INTERVAL_CYC = (period_ns(ROWS) / ROWS) / CLK_NS;
    localparam int CNT_MAX      = max_of(max_of(PAUSE_CYC, RAS_CYC), max_of(RP_CYC, CSR_CYC));
    localparam int CNT_W        = $clog2(CNT_MAX + 1);

    ref_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             keep_q, keep_d;
    logic             done_q, done_d;
    logic             take, load_init, tick, pend_nz, cnt_zero;

    dram_ref_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (done_q),
        .tick  (tick)
    );

    dram_ref_credit #(.INIT_CYCLES(INIT_CYCLES), .BURST_MAX(BURST_MAX)) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_init (load_init),
        .add       (tick),
        .take      (take),
        .pend_nz   (pend_nz)
    );

    assign cnt_zero = (cnt_q == '0);

    // next state and timers
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_zero ? cnt_q : cnt_q - 1'b1;
        keep_d    = keep_q;
        done_d    = done_q;
        take      = 1'b0;
        load_init = 1'b0;
        unique case (state_q)
            ST_PAUSE: if (cnt_zero) begin
                state_d   = ST_IDLE;
                load_init = 1'b1;
            end
            ST_IDLE: if (pend_nz) state_d = ST_REQ;
            ST_REQ: if (grant) begin
                state_d = ST_CASDN;
                cnt_d   = CNT_W'(CSR_CYC - 1);
            end
            ST_CASDN: if (cnt_zero) begin
                state_d = ST_RASLO;
                cnt_d   = CNT_W'(RAS_CYC - 1);
                take    = 1'b1;
            end
            ST_RASLO: if (cnt_zero) begin
                state_d = ST_PRECH;
                cnt_d   = CNT_W'(RP_CYC - 1);
                keep_d  = pend_nz && grant;
            end
            ST_PRECH: if (cnt_zero) begin
                if (keep_q && grant && pend_nz) begin
                    state_d = ST_RASLO;
                    cnt_d   = CNT_W'(RAS_CYC - 1);
                    take    = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                    keep_d  = 1'b0;
                    if (!pend_nz) done_d = 1'b1;
                end
            end
            default: state_d = ST_PAUSE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
            cnt_q   <= CNT_W'(PAUSE_CYC - 1);
            keep_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            keep_q  <= keep_d;
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_CASDN) || (state_q == ST_RASLO) || (state_q == ST_PRECH);
        req       = busy || (state_q == ST_REQ);
        ras_n     = (state_q != ST_RASLO);
        cas_lo_n  = !((state_q == ST_CASDN) || (state_q == ST_RASLO) ||
                      ((state_q == ST_PRECH) && keep_q));
        cas_hi_n  = cas_lo_n;
        init_done = done_q;
        we_n      = 1'b1;
        oe_n      = 1'b1;
    end
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
    parameter int CLK_NS   = 8,
    parameter int PAUSE_NS = 200_000,
    parameter int CSR_NS   = 5,
    parameter int CHR_NS   = 10,
    parameter int RAS_NS   = 80,
    parameter int RP_NS    = 60
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic init_done,
    input logic ras_n,
    input logic cas_lo_n,
    input logic cas_hi_n
);
    import dram_ref_pkg::*;

    localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_NS);
    localparam int CSR_CYC   = max_of(ns_to_cyc(CSR_NS, CLK_NS), 1);
    localparam int RAS_CYC   = max_of(ns_to_cyc(RAS_NS, CLK_NS), ns_to_cyc(CHR_NS, CLK_NS));
    localparam int RP_CYC    = max_of(ns_to_cyc(RP_NS, CLK_NS), CSR_CYC);

    logic [31:0] since_rst, cas_run, lo_run, hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            cas_run   <= '0;
            lo_run    <= '0;
            hi_run    <= '0;
        end else begin
            if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1;
            cas_run <= cas_lo_n ? '0 : cas_run + 1;
            lo_run  <= ras_n ? '0 : lo_run + 1;
            hi_run  <= ras_n ? ((hi_run == 32'hFFFF_FFFF) ? hi_run : hi_run + 1) : '0;
        end
    end

    assert_quiet_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 32'(PAUSE_CYC)) |-> (!req && ras_n && cas_lo_n && !init_done));

    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_cas_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (cas_run >= 32'(CSR_CYC)));

    assert_cas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (!cas_lo_n && !cas_hi_n));

    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_run == 32'(RAS_CYC)));

    assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_run >= 32'(RP_CYC)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ras_n && cas_lo_n && cas_hi_n));

    assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_lo_n || !cas_hi_n) |-> busy);
endmodule

bind dram_refresh_seq dram_refresh_chk #(
    .CLK_NS   (CLK_NS),
    .PAUSE_NS (PAUSE_NS),
    .CSR_NS   (CSR_NS),
    .CHR_NS   (CHR_NS),
    .RAS_NS   (RAS_NS),
    .RP_NS    (RP_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .busy      (busy),
    .init_done (init_done),
    .ras_n     (ras_n),
    .cas_lo_n  (cas_lo_n),
    .cas_hi_n  (cas_hi_n)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;

    localparam int T_NS         = 8;
    localparam int EXP_PAUSE    = (200_000 + T_NS - 1) / T_NS;
    localparam int EXP_CSR      = (5 + T_NS - 1) / T_NS;
    localparam int EXP_RAS      = (80 + T_NS - 1) / T_NS;
    localparam int EXP_RP       = (60 + T_NS - 1) / T_NS;
    localparam int EXP_INTERVAL = (32_000_000 / 4096) / T_NS;
    localparam int EXP_INIT     = 8;
    localparam int EXP_BURST    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b1;
    logic req, busy, init_done, ras_n, cas_lo_n, cas_hi_n, we_n, oe_n;

    int checks = 0;
    int errors = 0;

    // monitor state
    int cyc = 0, falls = 0, cas_rises = 0, last_fall = 0, period = 0;
    int bad_csr = 0, bad_rasw = 0, bad_prech = 0, bad_hold = 0;
    int bad_idle = 0, bad_weoe = 0, bad_busy = 0;
    int lo_run = 0, hi_run = 0, cas_run = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;

    always #4 clk = ~clk;

    dram_refresh_seq uut (
        .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .busy(busy),
        .init_done(init_done), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
        .cas_hi_n(cas_hi_n), .we_n(we_n), .oe_n(oe_n)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            prev_ras = 1'b1; prev_cas = 1'b1;
            lo_run = 0; hi_run = 0; cas_run = 0;
        end else begin
            if (prev_ras && !ras_n) begin
                falls = falls + 1;
                if (cas_run < EXP_CSR) bad_csr = bad_csr + 1;
                if (falls > 1 && hi_run < EXP_RP) bad_prech = bad_prech + 1;
                period = cyc - last_fall;
                last_fall = cyc;
            end
            if (!prev_ras && ras_n && lo_run != EXP_RAS) bad_rasw = bad_rasw + 1;
            if (!ras_n && (cas_lo_n || cas_hi_n)) bad_hold = bad_hold + 1;
            if (!prev_cas && cas_lo_n) cas_rises = cas_rises + 1;
            if (!grant && (!ras_n || !cas_lo_n || !cas_hi_n)) bad_idle = bad_idle + 1;
            if (!we_n || !oe_n) bad_weoe = bad_weoe + 1;
            if ((!ras_n || !cas_lo_n || !cas_hi_n) && !busy) bad_busy = bad_busy + 1;
            lo_run  = ras_n ? 0 : lo_run + 1;
            hi_run  = ras_n ? hi_run + 1 : 0;
            cas_run = cas_lo_n ? 0 : cas_run + 1;
            prev_ras = ras_n;
            prev_cas = cas_lo_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_falls(input int n);
        int start = falls;
        for (int i = 0; i < 3 * EXP_INTERVAL * (n + 1) && falls < start + n; i++)
            @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(ras_n && cas_lo_n && cas_hi_n, "R1 strobes in reset", {ras_n, cas_lo_n, cas_hi_n}, 7);
        chk(!req && !busy && !init_done, "R1 req/busy/done in reset", {req, busy, init_done}, 0);
    endtask

    task automatic t_pause();
        int n = 0;
        rst_n = 1'b1;
        while (!req && n < EXP_PAUSE + 100) begin
            @(negedge clk);
            n++;
        end
        chk(n >= EXP_PAUSE && n <= EXP_PAUSE + 2, "R1 first request after pause", n, EXP_PAUSE + 1);
        chk(falls == 0, "R1 no RAS pulse in pause", falls, 0);
    endtask

    task automatic t_init();
        int n = 0;
        while (!init_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(falls == EXP_INIT, "R2 wake-up pulse count", falls, EXP_INIT);
        chk(bad_csr == 0, "R3 CAS set-up before RAS", bad_csr, 0);
        chk(bad_hold == 0, "R4 CAS held while RAS low", bad_hold, 0);
        chk(bad_rasw == 0, "R5 RAS low width", bad_rasw, 0);
        chk(bad_prech == 0, "R5 RAS precharge", bad_prech, 0);
    endtask

    task automatic t_periodic();
        wait_falls(1);
        wait_falls(1);
        chk(period == EXP_INTERVAL, "R8 refresh spacing", period, EXP_INTERVAL);
        wait_falls(1);
        chk(period == EXP_INTERVAL, "R8 refresh spacing again", period, EXP_INTERVAL);
        chk(init_done, "R2 done stays set", init_done, 1);
    endtask

    task automatic t_withhold(input int half_ivals, input int exp_n, input string tag);
        int f0, r0, n;
        wait_idle();
        grant = 1'b0;
        f0 = falls;
        repeat (half_ivals * EXP_INTERVAL / 2) @(negedge clk);
        chk(falls == f0, "R7 no pulse while grant low", falls - f0, 0);
        chk(req && !busy, "R7 request held, not busy", {req, busy}, 2);
        chk(bad_idle == 0, "R7 strobes quiet without grant", bad_idle, 0);
        r0 = cas_rises;
        grant = 1'b1;
        n = 0;
        while (!busy && n < 100) begin @(negedge clk); n++; end
        wait_idle();
        chk(falls - f0 == exp_n, tag, falls - f0, exp_n);
        chk(cas_rises - r0 == 1, "R9 CAS low through whole chain", cas_rises - r0, 1);
        chk(bad_hold == 0 && bad_rasw == 0 && bad_prech == 0, "R4 R5 timing in chain",
            bad_hold + bad_rasw + bad_prech, 0);
    endtask

    initial begin
        #(T_NS * 200_000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pause();
        t_init();
        t_periodic();
        t_withhold(7, 3, "R9 three stored credits replayed");
        t_withhold(15, EXP_BURST, "R9 credits saturate at burst limit");
        chk(bad_weoe == 0, "R6 write and output enables high", bad_weoe, 0);
        chk(bad_busy == 0, "R10 busy covers strobe activity", bad_busy, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule